// File: doc/BRIEF.md
# Dual-Counter Multi-Mode Timer

This peripheral holds two 16-bit down-counters and two 16-bit registers, A and B. The registers act as reload values or as capture latches, depending on the selected mode. Each counter picks its own count enable. The choices are nothing, a tick from a 5-bit system-clock prescaler, a qualified edge on the timer pin, or a rising edge of an asynchronous slow clock.

One bidirectional timer pin, split into `pin_in`, `pin_out` and `pin_oe`, carries the PWM waveform or the external event. Two sticky interrupt flags, each with an enable, drive `irq_a` and `irq_b`. Software reaches everything through a flat write port and a combinational read port.

A small state machine drives the mode behaviour. The states are `ST_IDLE`, `ST_PWM_HI`, `ST_PWM_LO`, `ST_CAP_A`, `ST_CAP_B` and `ST_DUAL`. Reset enters `ST_IDLE`. Every write to the control register moves the machine to the entry state of the written mode: PWM goes to `ST_PWM_HI`, both capture modes go to `ST_CAP_A`, and dual timer goes to `ST_DUAL`. The machine makes these transitions:
- `ST_PWM_HI` to `ST_PWM_LO` on a counter-1 underflow, and back again on the next counter-1 underflow.
- `ST_CAP_A` to `ST_CAP_B` on an event in capture mode, and `ST_CAP_B` back to `ST_CAP_A` on the next event.
- In capture-plus-counter mode the machine stays in `ST_CAP_A`.
- `ST_IDLE` and `ST_DUAL` leave only on a control write.

Top module: `dual_mode_timer`

Register map (read at `rd_addr`, written at `wr_addr`):
- 0: control. Bits [1:0] hold the mode: 0 PWM, 1 capture, 2 capture plus counter, 3 dual timer. Bits [3:2] hold the source for counter 1 and bits [5:4] the source for counter 2, encoded 0 off, 1 prescaler, 2 pin event, 3 slow clock. Bit 6 selects the falling pin edge (0 selects the rising edge). Bit 7 enables interrupt A and bit 8 enables interrupt B.
- 1: prescaler divisor P, in bits [4:0].
- 2 and 3: counter 1 and counter 2.
- 4 and 5: registers A and B.
- 6: flags, with bit 0 for A and bit 1 for B. Writing 1 to a bit clears it.

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pin_oe`, `irq_a` and `irq_b` are 0, and the machine is in `ST_IDLE`.
- R2: The prescaler tick occurs once every P+1 system clocks, so a counter fed by it with reload value N underflows every (N+1)*(P+1) clocks.
- R3: Source code 0 holds a counter frozen. A software write to address 2 or 3 loads the counter directly. A control write leaves the counters and flags unchanged.
- R4: With source code 2, a counter decrements once per pin edge of the polarity chosen by control bit 6, and edges of the other polarity are ignored.
- R5: With source code 3, a counter decrements once per rising edge of `slow_clk`, for a slow clock at most a quarter of the system clock.
- R6: In PWM mode `pin_oe` is 1. `pin_out` stays high for (A+1)*(P+1) clocks and low for (B+1)*(P+1) clocks. Counter 1 reloads from B at the end of the high phase and from A at the end of the low phase. Flag A sets at the high-to-low change and flag B at the low-to-high change.
- R7: In capture mode, qualified pin edges copy counter 1 into A, then B, then A, in alternation. Each capture sets flag A, and a pin edge of the other polarity captures nothing.
- R8: In capture mode, a counter-1 underflow wraps the counter to 0xFFFF and sets flag B.
- R9: In capture-plus-counter mode, every qualified edge captures counter 1 into A and B is never overwritten. Counter 2 reloads from B and sets flag B on each underflow.
- R10: In dual timer mode, counter 1 reloads from A and sets flag A on underflow. Counter 2 reloads from B and sets flag B on underflow, and `pin_oe` is 0.
- R11: Flags stay set until software writes 1 to their bit at address 6; each bit clears only itself. `irq_a` and `irq_b` follow their flags only while control bits 7 and 8 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| pin_in | input | 1 | Timer pin input (event / count source) |
| slow_clk | input | 1 | Asynchronous slow clock |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| irq_a | output | 1 | Interrupt A |
| irq_b | output | 1 | Interrupt B |

## Verification
The checker watches several rules on every cycle:
- Flag A stays set unless software clears it.
- The prescaler tick never repeats in back-to-back cycles when P is nonzero.
- Each pin event lasts a single cycle.
- A counter with no tick and no write holds its value.
- Every counter-1 underflow in a PWM state flips the pin.
- A capture in `ST_CAP_A` latches the counter value of the cycle before.

The scenarios show what spans many cycles. These are the exact high, low and underflow periods for random A, B and P, the alternating capture pointer, and the ignored opposite edge. They also show slow-clock counting, and that the interrupt enables and the per-bit clear act separately.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int DW = 16;
    localparam int PW = 5;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        MODE_PWM    = 2'd0,
        MODE_CAP    = 2'd1,
        MODE_CAPCNT = 2'd2,
        MODE_DUAL   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_PRE  = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_SLOW = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PWM_HI = 3'd1,
        ST_PWM_LO = 3'd2,
        ST_CAP_A  = 3'd3,
        ST_CAP_B  = 3'd4,
        ST_DUAL   = 3'd5
    } state_e;

    localparam logic [AW-1:0] ADR_CTRL  = 3'd0;
    localparam logic [AW-1:0] ADR_PRESC = 3'd1;
    localparam logic [AW-1:0] ADR_CNT1  = 3'd2;
    localparam logic [AW-1:0] ADR_CNT2  = 3'd3;
    localparam logic [AW-1:0] ADR_REGA  = 3'd4;
    localparam logic [AW-1:0] ADR_REGB  = 3'd5;
    localparam logic [AW-1:0] ADR_FLAGS = 3'd6;
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dmt_sync_edge.sv
module dmt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic pulse
);
    localparam int TOP = STAGES;
    logic [TOP:0] sh_q;
    logic         cur, prev;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[TOP-1:0], din};
    end

    assign cur   = sh_q[TOP-1];
    assign prev  = sh_q[TOP];
    assign pulse = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/dmt_clk_sel.sv
module dmt_clk_sel
    import dmt_pkg::*;
(
    input  src_e sel,
    input  logic pre_tick,
    input  logic pin_ev,
    input  logic slow_ev,
    output logic tick
);
    always_comb begin
        unique case (sel)
            SRC_OFF:  tick = 1'b0;
            SRC_PRE:  tick = pre_tick;
            SRC_PIN:  tick = pin_ev;
            SRC_SLOW: tick = slow_ev;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload_en,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         uf
);
    assign uf = tick && (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (uf)    count <= reload_en ? reload_val : '1;
        else if (tick)  count <= count - 1'b1;
    end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter int W      = DW,
    parameter int PRE_W  = PW,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          pin_in,
    input  logic          slow_clk,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          irq_a,
    output logic          irq_b
);
    localparam int NCNT = 2;
    localparam int CTRL_W = 9;

    mode_e            mode_q;
    src_e             src_q [NCNT];
    logic             fall_q, ien_a_q, ien_b_q;
    logic [PRE_W-1:0] presc_q;
    logic [W-1:0]     reg_a, reg_b;
    logic             flag_a, flag_b;
    state_e           st_q, st_d;

    logic wr_ctrl, wr_presc, wr_a, wr_b, wr_flags;
    logic [NCNT-1:0] wr_cnt;
    logic pre_tick, pin_ev, slow_ev;
    logic [NCNT-1:0] tick, uf, rld_en;
    logic [W-1:0] cnt_q   [NCNT];
    logic [W-1:0] rld_val [NCNT];
    logic [W-1:0] cnt1, cnt2;
    logic cap_a, cap_b, set_a, set_b;

    assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
    assign wr_presc = wr_en && (wr_addr == ADR_PRESC);
    assign wr_cnt[0]= wr_en && (wr_addr == ADR_CNT1);
    assign wr_cnt[1]= wr_en && (wr_addr == ADR_CNT2);
    assign wr_a     = wr_en && (wr_addr == ADR_REGA);
    assign wr_b     = wr_en && (wr_addr == ADR_REGB);
    assign wr_flags = wr_en && (wr_addr == ADR_FLAGS);

    dmt_prescaler #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div(presc_q), .tick(pre_tick)
    );

    dmt_sync_edge #(.STAGES(SYNC_N)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .fall_sel(fall_q), .pulse(pin_ev)
    );

    dmt_sync_edge #(.STAGES(SYNC_N)) u_slow_sync (
        .clk(clk), .rst_n(rst_n), .din(slow_clk), .fall_sel(1'b0), .pulse(slow_ev)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        dmt_clk_sel u_sel (
            .sel(src_q[i]), .pre_tick(pre_tick), .pin_ev(pin_ev),
            .slow_ev(slow_ev), .tick(tick[i])
        );
        dmt_counter #(.W(W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .tick(tick[i]), .load(wr_cnt[i]),
            .load_val(wr_data), .reload_en(rld_en[i]), .reload_val(rld_val[i]),
            .count(cnt_q[i]), .uf(uf[i])
        );
    end

    assign cnt1 = cnt_q[0];
    assign cnt2 = cnt_q[1];

    // Control and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_PWM;
            src_q[0] <= SRC_OFF;
            src_q[1] <= SRC_OFF;
            fall_q  <= 1'b0;
            ien_a_q <= 1'b0;
            ien_b_q <= 1'b0;
            presc_q <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q   <= mode_e'(wr_data[1:0]);
                src_q[0] <= src_e'(wr_data[3:2]);
                src_q[1] <= src_e'(wr_data[5:4]);
                fall_q   <= wr_data[6];
                ien_a_q  <= wr_data[7];
                ien_b_q  <= wr_data[8];
            end
            if (wr_presc) presc_q <= wr_data[PRE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a  <= '0;
            reg_b  <= '0;
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            if (cap_a)     reg_a <= cnt1;
            else if (wr_a) reg_a <= wr_data;
            if (cap_b)     reg_b <= cnt1;
            else if (wr_b) reg_b <= wr_data;
            flag_a <= set_a | (flag_a & ~(wr_flags & wr_data[0]));
            flag_b <= set_b | (flag_b & ~(wr_flags & wr_data[1]));
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = ST_IDLE;
            ST_PWM_HI: if (uf[0]) st_d = ST_PWM_LO;
            ST_PWM_LO: if (uf[0]) st_d = ST_PWM_HI;
            ST_CAP_A:  if (pin_ev && mode_q == MODE_CAP) st_d = ST_CAP_B;
            ST_CAP_B:  if (pin_ev) st_d = ST_CAP_A;
            ST_DUAL:   st_d = ST_DUAL;
            default:   st_d = ST_IDLE;
        endcase
        if (wr_ctrl) begin
            unique case (mode_e'(wr_data[1:0]))
                MODE_PWM:    st_d = ST_PWM_HI;
                MODE_CAP:    st_d = ST_CAP_A;
                MODE_CAPCNT: st_d = ST_CAP_A;
                MODE_DUAL:   st_d = ST_DUAL;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // State outputs
    always_comb begin
        rld_en     = '0;
        rld_val[0] = reg_a;
        rld_val[1] = reg_b;
        cap_a      = 1'b0;
        cap_b      = 1'b0;
        set_a      = 1'b0;
        set_b      = 1'b0;
        pin_out    = 1'b0;
        pin_oe     = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_PWM_HI: begin
                pin_oe     = 1'b1;
                pin_out    = 1'b1;
                rld_en[0]  = 1'b1;
                rld_val[0] = reg_b;
                set_a      = uf[0];
            end
            ST_PWM_LO: begin
                pin_oe     = 1'b1;
                rld_en[0]  = 1'b1;
                rld_val[0] = reg_a;
                set_b      = uf[0];
            end
            ST_CAP_A: begin
                cap_a = pin_ev;
                set_a = pin_ev;
                if (mode_q == MODE_CAPCNT) begin
                    rld_en[1] = 1'b1;
                    set_b     = uf[1];
                end else begin
                    set_b     = uf[0];
                end
            end
            ST_CAP_B: begin
                cap_b = pin_ev;
                set_a = pin_ev;
                set_b = uf[0];
            end
            ST_DUAL: begin
                rld_en = '1;
                set_a  = uf[0];
                set_b  = uf[1];
            end
            default: ;
        endcase
    end

    assign irq_a = flag_a & ien_a_q;
    assign irq_b = flag_b & ien_b_q;

    // Read port
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_CTRL:  rd_data[CTRL_W-1:0] = {ien_b_q, ien_a_q, fall_q,
                                              src_q[1], src_q[0], mode_q};
            ADR_PRESC: rd_data[PRE_W-1:0]  = presc_q;
            ADR_CNT1:  rd_data = cnt1;
            ADR_CNT2:  rd_data = cnt2;
            ADR_REGA:  rd_data = reg_a;
            ADR_REGB:  rd_data = reg_b;
            ADR_FLAGS: rd_data[1:0] = {flag_b, flag_a};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
    import dmt_pkg::*;
#(
    parameter int W = 16,
    parameter int PRE_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [W-1:0]     wr_data,
    input logic             flag_a,
    input logic [PRE_W-1:0] presc_q,
    input logic             pre_tick,
    input logic             pin_ev,
    input logic             pin_out,
    input state_e           st_q,
    input logic             tick1,
    input logic             uf1,
    input logic [W-1:0]     cnt1,
    input logic [W-1:0]     reg_a
);
    logic wr_c, wr_p, wr_n1, clr_a;
    assign wr_c  = wr_en && (wr_addr == ADR_CTRL);
    assign wr_p  = wr_en && (wr_addr == ADR_PRESC);
    assign wr_n1 = wr_en && (wr_addr == ADR_CNT1);
    assign clr_a = wr_en && (wr_addr == ADR_FLAGS) && wr_data[0];

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_a && !clr_a |=> flag_a); // R11

    AST_PRESC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick && (presc_q != '0) && !wr_p |=> !pre_tick); // R2

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_ev |=> !pin_ev); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick1 && !wr_n1 |=> $stable(cnt1)); // R3

    AST_PWM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PWM_HI || st_q == ST_PWM_LO) && uf1 && !wr_c
        |=> pin_out != $past(pin_out)); // R6

    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CAP_A) && pin_ev |=> reg_a == $past(cnt1)); // R7
endmodule

bind dual_mode_timer dmt_checker #(.W(W), .PRE_W(PRE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flag_a(flag_a), .presc_q(presc_q),
    .pre_tick(pre_tick), .pin_ev(pin_ev), .pin_out(pin_out), .st_q(st_q),
    .tick1(tick[0]), .uf1(uf[0]), .cnt1(cnt1), .reg_a(reg_a)
);

// File: tb/dual_mode_timer_test.sv
module dual_mode_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pin_in = 1'b0;
    logic        slow_clk = 1'b0;
    logic        pin_out, pin_oe, irq_a, irq_b;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    dual_mode_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .slow_clk(slow_clk), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] ctl(int mode, int s1, int s2, int fall, int ea, int eb);
        return 16'((mode & 3) | ((s1 & 3) << 2) | ((s2 & 3) << 4) |
                   ((fall & 1) << 6) | ((ea & 1) << 7) | ((eb & 1) << 8));
    endfunction

    function automatic int period(int n, int p);
        return (n + 1) * (p + 1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(logic v);
        @(negedge clk);
        pin_in = v;
        idle(4);
    endtask

    task automatic wait_sig(int which, logic lvl);
        forever begin
            if (which == 0 && irq_a == lvl) break;
            if (which == 1 && irq_b == lvl) break;
            if (which == 2 && pin_out == lvl) break;
            @(negedge clk);
        end
    endtask

    task automatic irq_period(int which, output int per);
        int t0;
        wr(3'd6, 16'h3);
        wait_sig(which, 1'b1);
        t0 = cyc;
        wr(3'd6, which == 0 ? 16'h1 : 16'h2);
        wait_sig(which, 1'b1);
        per = cyc - t0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, per, n, m, p, t0, t1, t2;
        void'($urandom(32'd2024));
        idle(4);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 reg %0d", a), v, 0);
        end
        check("R1 outputs", int'({pin_out, pin_oe, irq_a, irq_b}), 0);

        // R3 frozen counter and direct load
        wr(3'd0, ctl(3, 0, 0, 0, 0, 0));
        wr(3'd2, 16'h1234);
        idle(10);
        rd(3'd2, v);
        check("R3 off source holds", v, 16'h1234);

        // R10 / R2 dual timer, random reloads and divisors
        for (int r = 0; r < 4; r++) begin
            n = 3 + int'($urandom % 16);
            m = 3 + int'($urandom % 16);
            p = int'($urandom % 4);
            wr(3'd1, 16'(p));
            wr(3'd4, 16'(n));
            wr(3'd5, 16'(m));
            wr(3'd0, ctl(3, 1, 1, 0, 1, 1));
            wr(3'd2, 16'd1);
            wr(3'd3, 16'd1);
            check("R10 dual pin_oe low", int'(pin_oe), 0);
            irq_period(0, per);
            check("R2 R10 counter1 period", per, period(n, p));
            irq_period(1, per);
            check("R2 R10 counter2 period", per, period(m, p));
        end

        // R6 PWM with random high/low reloads
        for (int r = 0; r < 3; r++) begin
            n = 1 + int'($urandom % 12);
            m = 1 + int'($urandom % 12);
            p = int'($urandom % 3);
            wr(3'd1, 16'(p));
            wr(3'd4, 16'(n));
            wr(3'd5, 16'(m));
            wr(3'd0, ctl(0, 1, 0, 0, 0, 0));
            wr(3'd2, 16'd1);
            check("R6 pwm pin_oe", int'(pin_oe), 1);
            wait_sig(2, 1'b0);
            wait_sig(2, 1'b1); t0 = cyc;
            wait_sig(2, 1'b0); t1 = cyc;
            wait_sig(2, 1'b1); t2 = cyc;
            check("R6 high time", t1 - t0, period(n, p));
            check("R6 low time", t2 - t1, period(m, p));
        end

        // R7 capture alternation and ignored edge
        wr(3'd5, 16'h5555);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0));
        wr(3'd6, 16'h3);
        v = int'($urandom % 65536);
        wr(3'd2, 16'(v));
        set_pin(1'b1);
        rd(3'd4, n);
        check("R7 first capture to A", n, v);
        rd(3'd6, n);
        check("R7 flag A set", n & 1, 1);
        m = int'($urandom % 65536);
        wr(3'd2, 16'(m));
        set_pin(1'b0);
        rd(3'd5, n);
        check("R7 opposite edge ignored (B)", n, 16'h5555);
        rd(3'd4, n);
        check("R7 opposite edge ignored (A)", n, v);
        set_pin(1'b1);
        rd(3'd5, n);
        check("R7 second capture to B", n, m);
        // falling polarity
        wr(3'd0, ctl(1, 0, 0, 1, 0, 0));
        wr(3'd2, 16'h0BEE);
        set_pin(1'b0);
        rd(3'd4, n);
        check("R7 R4 falling polarity capture", n, 16'h0BEE);

        // R8 capture-mode underflow wraps and flags B
        wr(3'd1, 16'd0);
        wr(3'd0, ctl(1, 1, 0, 1, 0, 0));
        wr(3'd2, 16'd5);
        wr(3'd6, 16'h3);
        idle(12);
        rd(3'd6, n);
        check("R8 flag B on wrap", (n >> 1) & 1, 1);
        rd(3'd2, n);
        check("R8 wrapped near 0xFFFF", int'(n >= 16'hFFE0), 1);

        // R9 capture plus counter
        pin_in = 1'b0;
        idle(4);
        wr(3'd1, 16'd1);
        wr(3'd5, 16'd5);
        wr(3'd0, ctl(2, 0, 1, 0, 0, 1));
        wr(3'd3, 16'd1);
        wr(3'd2, 16'h0111);
        set_pin(1'b1);
        set_pin(1'b0);
        wr(3'd2, 16'h0222);
        set_pin(1'b1);
        rd(3'd4, n);
        check("R9 second capture stays in A", n, 16'h0222);
        rd(3'd5, n);
        check("R9 B never captured", n, 5);
        irq_period(1, per);
        check("R9 counter2 period", per, period(5, 1));

        // R4 pin events as count source
        set_pin(1'b0);
        wr(3'd4, 16'd1000);
        wr(3'd0, ctl(3, 2, 0, 0, 0, 0));
        wr(3'd2, 16'd20);
        for (int k = 0; k < 5; k++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
        rd(3'd2, n);
        check("R4 rising edges counted", n, 15);
        wr(3'd0, ctl(3, 2, 0, 1, 0, 0));
        for (int k = 0; k < 3; k++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
        rd(3'd2, n);
        check("R4 falling edges counted", n, 12);

        // R5 slow clock source
        wr(3'd0, ctl(3, 3, 0, 0, 0, 0));
        wr(3'd2, 16'd100);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk) slow_clk = 1'b1;
            idle(4);
            @(negedge clk) slow_clk = 1'b0;
            idle(4);
        end
        idle(4);
        rd(3'd2, n);
        check("R5 slow clock edges", n, 90);

        // R11 enable gating and per-bit clear
        wr(3'd1, 16'd0);
        wr(3'd4, 16'd3);
        wr(3'd5, 16'd3);
        wr(3'd0, ctl(3, 1, 1, 0, 0, 0));
        wr(3'd2, 16'd1);
        wr(3'd3, 16'd1);
        idle(20);
        check("R11 irq gated off", int'({irq_a, irq_b}), 0);
        rd(3'd6, n);
        check("R11 flags set", n, 3);
        wr(3'd0, ctl(3, 0, 0, 0, 1, 1));
        check("R11 irq follows flags", int'({irq_a, irq_b}), 3);
        check("R3 ctrl write keeps flags", int'(irq_a & irq_b), 1);
        wr(3'd6, 16'h2);
        rd(3'd6, n);
        check("R11 clear B only", n, 1);
        idle(5);
        rd(3'd6, n);
        check("R11 flag A sticky", n, 1);
        wr(3'd6, 16'h1);
        rd(3'd6, n);
        check("R11 clear A", n, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule